// File: doc/BRIEF.md
# Interrupt-Vector DMA Channel Router

This block sits between the interrupt sources and the CPU. It holds a small bank of transfer channels. Each channel keeps a programmable start vector and a transfer counter. When an interrupt request arrives, its vector is compared with every armed channel's start vector. On a hit, the request becomes a one-transfer grant to a channel and the CPU does not see it. On a miss, the request goes on to the CPU unchanged.

Each channel counts its completed transfers down. On the step that takes the count to zero, the channel raises a one-cycle end interrupt and clears its own start vector, which disarms it. If more than one channel holds the same vector, the lowest-numbered channel wins. When that channel disarms, later requests with the vector pass to the next channel that still holds it. This gives a chain of transfers across channels.

Requests enter on a valid/ready stream. `req_ready` is tied high, so the block accepts one request in every cycle and never applies back-pressure. The upstream side may hold `req_valid` high for consecutive cycles, and each cycle counts as a separate request. Both result outputs are registered and reported one cycle after acceptance, each as a one-cycle valid pulse with no ready.

Top module: `dma_vec_router`

## Requirements
- R1: After reset, all counters read 0, no grant, CPU forward or end pulse is active, and every channel is disarmed (start vector 0).
- R2: A request accepted at a clock edge whose vector equals a channel's nonzero start vector gives `grant_valid`=1 with `grant_ch` one-hot on that channel (bit i = channel i) during the following cycle, and `cpu_irq_valid`=0.
- R3: A request that matches no armed channel, including any request with vector 0, gives `cpu_irq_valid`=1 with `cpu_irq_vec` equal to the request vector in the following cycle, and no grant.
- R4: When several channels hold the matching vector, the grant goes to the lowest-numbered one.
- R5: A pulse on `xfer_done[i]` lowers channel i's counter by one at that clock. A pulse on a counter that is already 0 changes nothing and raises no end pulse.
- R6: The decrement that takes a counter from 1 to 0 gives a single-cycle `end_irq[i]` pulse in the following cycle and clears the start vector. Later requests with that vector go to the next higher channel that still holds it, or to the CPU if none does.
- R7: A software write (`wr_sel` 0 = start vector, taken from `wr_data[5:0]`; `wr_sel` 1 = counter) takes effect at the next clock. A start-vector write at the same edge as an automatic clear keeps the written value. A counter write at the same edge as a done pulse keeps the written value and raises no end pulse.
- R8: `req_ready` is always 1. Each accepted request gives exactly one of `grant_valid` or `cpu_irq_valid` in the following cycle. A cycle with no request gives neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Interrupt request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_vec | input | 6 | Vector of the request |
| wr_en | input | 1 | Software write strobe |
| wr_ch | input | 2 | Channel addressed by the write |
| wr_sel | input | 1 | 0 = start vector, 1 = counter |
| wr_data | input | 16 | Write data |
| xfer_done | input | 4 | Per-channel transfer-done pulses |
| grant_valid | output | 1 | A request was routed to a channel |
| grant_ch | output | 4 | One-hot channel of the grant |
| cpu_irq_valid | output | 1 | A request was forwarded to the CPU |
| cpu_irq_vec | output | 6 | Vector forwarded to the CPU |
| cnt_flat | output | 64 | Counters, channel i at bits [16i+15:16i] |
| end_irq | output | 4 | Per-channel end-of-transfer pulses |

## Verification
The routing is tried with every one of the 64 request vectors in three configurations:
- **All channels disarmed.** This separates matching from forwarding.
- **Distinct vectors in every channel.** This shows that each channel matches only its own code and that vector 0 never matches.
- **One vector held by two channels, with a third channel holding another.** This shows the lowest-index priority.

Count-down sequences take a channel through 2→1→0 and then apply one more done pulse at zero. They also apply done pulses at the same edge as software writes. These show the end pulse, the disarm with hand-over to the next channel, and which write wins.

// File: rtl/dvr_pkg.sv
package dvr_pkg;
  // Default geometry of the router
  localparam int DVR_CHANNELS = 4;
  localparam int DVR_VEC_W    = 6;
  localparam int DVR_CNT_W    = 16;

  // Target of a software write
  typedef enum logic {
    WSEL_VECTOR  = 1'b0,
    WSEL_COUNTER = 1'b1
  } wsel_e;
endpackage

// File: rtl/dvr_channel.sv
module dvr_channel #(
  parameter int VEC_W = 6,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_vec,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             done,
  output logic [VEC_W-1:0] vec_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             end_o
);
  logic [VEC_W-1:0] vec_q;
  logic [CNT_W-1:0] cnt_q;
  logic             end_q;
  logic             step;
  logic             last;

  // A done pulse counts unless a counter write overrides it
  assign step = done && !wr_cnt && (cnt_q != '0);
  assign last = step && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      cnt_q <= '0;
      end_q <= 1'b0;
    end else begin
      end_q <= last;
      if (wr_cnt)    cnt_q <= wr_data;
      else if (step) cnt_q <= cnt_q - CNT_W'(1);
      if (wr_vec)    vec_q <= wr_data[VEC_W-1:0];
      else if (last) vec_q <= '0;
    end
  end

  assign vec_o = vec_q;
  assign cnt_o = cnt_q;
  assign end_o = end_q;

  // R6: the end pulse lasts one cycle and finds the counter at zero
  a_r6_end_single: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |=> !end_q);
  a_r6_end_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |-> (cnt_q == '0));
  // R6: a channel that has just ended is disarmed unless rewritten
  a_r6_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (end_q && !$past(wr_vec)) |-> (vec_q == '0));
  // R5: a done pulse at zero leaves the counter alone
  a_r5_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_cnt && cnt_q == '0) |=> (cnt_q == '0 && !end_q));
  // R7: a vector write is visible on the next clock
  a_r7_vec_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vec |=> (vec_q == $past(wr_data[VEC_W-1:0])));
endmodule

// File: rtl/dvr_match.sv
module dvr_match #(
  parameter int NUM_CH = 4,
  parameter int VEC_W  = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CH-1:0][VEC_W-1:0] vecs,
  input  logic [VEC_W-1:0]            req_vec,
  output logic                        hit,
  output logic [NUM_CH-1:0]           sel
);
  logic [NUM_CH-1:0] eq;

  // Disarmed channels (vector 0) never compare equal
  for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
    assign eq[g] = (vecs[g] != '0) && (vecs[g] == req_vec);
  end

  // Lowest index wins: scan from the top down, keeping the last hit
  always_comb begin
    sel = '0;
    hit = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (eq[i]) begin
        sel    = '0;
        sel[i] = 1'b1;
        hit    = 1'b1;
      end
    end
  end

  // R4: at most one channel selected, and only among equal ones
  a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel) && ((sel & ~eq) == '0));
  // R4: nothing below the selected channel also matched
  a_r4_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((eq & (sel - NUM_CH'(1))) == '0));
endmodule

// File: rtl/dma_vec_router.sv
module dma_vec_router
  import dvr_pkg::*;
#(
  parameter int NUM_CH = DVR_CHANNELS,
  parameter int VEC_W  = DVR_VEC_W,
  parameter int CNT_W  = DVR_CNT_W,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [VEC_W-1:0]        req_vec,
  input  logic                    wr_en,
  input  logic [CH_W-1:0]         wr_ch,
  input  logic                    wr_sel,
  input  logic [CNT_W-1:0]        wr_data,
  input  logic [NUM_CH-1:0]       xfer_done,
  output logic                    grant_valid,
  output logic [NUM_CH-1:0]       grant_ch,
  output logic                    cpu_irq_valid,
  output logic [VEC_W-1:0]        cpu_irq_vec,
  output logic [NUM_CH*CNT_W-1:0] cnt_flat,
  output logic [NUM_CH-1:0]       end_irq
);
  logic [NUM_CH-1:0][VEC_W-1:0] vecs;
  logic [NUM_CH-1:0]            sel;
  logic                         hit;
  logic                         grant_q, cpu_q;
  logic [NUM_CH-1:0]            grant_ch_q;
  logic [VEC_W-1:0]             cpu_vec_q;

  assign req_ready = 1'b1;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic wv, wc;
    assign wv = wr_en && (wr_ch == CH_W'(g)) && (wsel_e'(wr_sel) == WSEL_VECTOR);
    assign wc = wr_en && (wr_ch == CH_W'(g)) && (wsel_e'(wr_sel) == WSEL_COUNTER);
    dvr_channel #(.VEC_W(VEC_W), .CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_vec  (wv),
      .wr_cnt  (wc),
      .wr_data (wr_data),
      .done    (xfer_done[g]),
      .vec_o   (vecs[g]),
      .cnt_o   (cnt_flat[g*CNT_W +: CNT_W]),
      .end_o   (end_irq[g])
    );
  end

  dvr_match #(.NUM_CH(NUM_CH), .VEC_W(VEC_W)) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .vecs    (vecs),
    .req_vec (req_vec),
    .hit     (hit),
    .sel     (sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q    <= 1'b0;
      grant_ch_q <= '0;
      cpu_q      <= 1'b0;
      cpu_vec_q  <= '0;
    end else begin
      grant_q    <= req_valid && hit;
      grant_ch_q <= (req_valid && hit) ? sel : '0;
      cpu_q      <= req_valid && !hit;
      if (req_valid && !hit) cpu_vec_q <= req_vec;
    end
  end

  assign grant_valid   = grant_q;
  assign grant_ch      = grant_ch_q;
  assign cpu_irq_valid = cpu_q;
  assign cpu_irq_vec   = cpu_vec_q;

  // R8: one outcome per accepted request, none without one
  a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (grant_valid ^ cpu_irq_valid));
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!grant_valid && !cpu_irq_valid));
  // R2: a grant names exactly one channel
  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ($countones(grant_ch) == 1));
  // R3: the forwarded vector is the one requested
  a_r3_fwd_vec: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq_valid |-> (cpu_irq_vec == $past(req_vec)));
endmodule

// File: tb/dma_vec_router_test.sv
module dma_vec_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_vec = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_ch = '0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [3:0]  xfer_done = '0;
  logic        grant_valid;
  logic [3:0]  grant_ch;
  logic        cpu_irq_valid;
  logic [5:0]  cpu_irq_vec;
  logic [63:0] cnt_flat;
  logic [3:0]  end_irq;

  int checks = 0;
  int errors = 0;
  logic [5:0] mvec [4];

  always #5 clk = ~clk;

  dma_vec_router uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vec(req_vec), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
    .wr_data(wr_data), .xfer_done(xfer_done), .grant_valid(grant_valid),
    .grant_ch(grant_ch), .cpu_irq_valid(cpu_irq_valid),
    .cpu_irq_vec(cpu_irq_vec), .cnt_flat(cnt_flat), .end_irq(end_irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cnt_of(input int ch);
    return cnt_flat[ch*16 +: 16];
  endfunction

  task automatic sw_write(input int ch, input bit sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = 2'(ch); wr_sel = sel; wr_data = d;
    if (!sel) mvec[ch] = d[5:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Sends one request and checks the result against the model
  task automatic send(input logic [5:0] v, input string req);
    int exp_ch;
    exp_ch = -1;
    for (int i = 3; i >= 0; i--)
      if (v != 0 && mvec[i] == v) exp_ch = i;
    @(negedge clk);
    req_valid = 1'b1; req_vec = v;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_ch < 0)
      chk(cpu_irq_valid && !grant_valid && cpu_irq_vec == v, req,
          {grant_valid, cpu_irq_valid, cpu_irq_vec}, {2'b01, v});
    else
      chk(grant_valid && !cpu_irq_valid && grant_ch == 4'(1 << exp_ch), req,
          {grant_valid, cpu_irq_valid, grant_ch}, {2'b10, 4'(1 << exp_ch)});
  endtask

  task automatic pulse_done(input logic [3:0] m);
    @(negedge clk);
    xfer_done = m;
    @(negedge clk);
    xfer_done = '0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) mvec[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(cnt_flat == '0 && end_irq == '0 && !grant_valid && !cpu_irq_valid,
        "R1 reset outputs", {end_irq, 2'b0, grant_valid, cpu_irq_valid}, 0);
    chk(req_ready, "R8 ready high", req_ready, 1);
    // R1 R3: all disarmed, every vector forwarded
    for (int v = 0; v < 64; v++) send(6'(v), "R3 disarmed sweep");
    // R8: idle cycle gives no outcome
    @(negedge clk);
    chk(!grant_valid && !cpu_irq_valid, "R8 idle", {grant_valid, cpu_irq_valid}, 0);

    // R2: distinct vectors, full sweep
    for (int i = 0; i < 4; i++) sw_write(i, 1'b0, 16'(8 + 9 * i));
    for (int v = 0; v < 64; v++) send(6'(v), "R2 distinct sweep");

    // R4: duplicate vector in channels 1 and 3
    sw_write(0, 1'b0, 16'h3F);
    sw_write(1, 1'b0, 16'h0A);
    sw_write(2, 1'b0, 16'h00);
    sw_write(3, 1'b0, 16'h0A);
    for (int v = 0; v < 64; v++) send(6'(v), "R4 duplicate sweep");
    send(6'h0A, "R4 lowest of pair");

    // R5 R6: count down channel 1 from 2
    sw_write(1, 1'b1, 16'd2);
    chk(cnt_of(1) == 16'd2, "R7 counter write", cnt_of(1), 2);
    pulse_done(4'b0010);
    chk(cnt_of(1) == 16'd1 && end_irq == '0, "R5 decrement", cnt_of(1), 1);
    @(negedge clk);
    xfer_done = 4'b0010;
    @(posedge clk);
    #1 xfer_done = '0;
    @(negedge clk);
    chk(cnt_of(1) == 16'd0, "R6 reaches zero", cnt_of(1), 0);
    chk(end_irq == 4'b0010, "R6 end pulse", end_irq, 4'b0010);
    @(negedge clk);
    chk(end_irq == '0, "R6 end one cycle", end_irq, 0);
    mvec[1] = '0;
    send(6'h0A, "R6 chain to channel 3");
    pulse_done(4'b0010);
    chk(cnt_of(1) == 16'd0 && end_irq == '0, "R5 done at zero ignored",
        {end_irq, cnt_of(1)}, 0);
    @(negedge clk);
    chk(end_irq == '0, "R5 no late end", end_irq, 0);

    // R7: vector write wins over automatic clear on channel 3
    sw_write(3, 1'b1, 16'd1);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = 2'd3; wr_sel = 1'b0; wr_data = 16'h15; xfer_done = 4'b1000;
    mvec[3] = 6'h15;
    @(negedge clk);
    wr_en = 1'b0; xfer_done = '0;
    chk(end_irq == 4'b1000 && cnt_of(3) == 0, "R6 end with rewrite",
        {end_irq, cnt_of(3)}, {4'b1000, 16'd0});
    send(6'h15, "R7 vector write wins");
    send(6'h0A, "R6 chain exhausted to CPU");

    // R7: counter write wins over done pulse
    sw_write(2, 1'b1, 16'd1);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = 2'd2; wr_sel = 1'b1; wr_data = 16'd7; xfer_done = 4'b0100;
    @(negedge clk);
    wr_en = 1'b0; xfer_done = '0;
    chk(cnt_of(2) == 16'd7 && end_irq == '0, "R7 counter write wins",
        {end_irq, cnt_of(2)}, {4'b0, 16'd7});
    @(negedge clk);
    chk(end_irq == '0, "R7 no end after override", end_irq, 0);

    // R5: all channels stepping at once
    for (int i = 0; i < 4; i++) sw_write(i, 1'b1, 16'(100 + i));
    pulse_done(4'b1111);
    for (int i = 0; i < 4; i++)
      chk(cnt_of(i) == 16'(99 + i), "R5 parallel decrement", cnt_of(i), 99 + i);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule